// File: doc/BRIEF.md
# Directional Rectangle Copy Engine

This block moves a rectangle of pixels from one place in a shared video memory to another. The command's operands are held on input ports: source and destination coordinates, a width and a height in pixels, a pixel-format code, two direction bits, and a choice between per-operand pitch/base values and one shared default pitch/base. A one-cycle `start` pulse captures these operands. The engine checks them, then copies the rectangle one byte at a time through a synchronous memory port. Memory addresses count bytes. A read returns data on the cycle after its request.

Each direction bit decides how the programmed coordinate is read. When the bit is set, the coordinate is the near edge (left or top). When the bit is clear, it is the far edge (right or bottom). The walk order follows the same bits: columns run right to left when the X bit is clear, and the bottom row goes first when the Y bit is clear. A copy between overlapping source and destination areas therefore gives the correct result without a staging buffer. At the end of a copy the engine reports new destination coordinates on its position outputs. A command that fails the checks ends with an error pulse and makes no memory access.

Top module: `rce_engine`

## Requirements
- R1: `fmt_code` sets the bytes per pixel: 2 gives 1, 3 and 4 give 2, 5 gives 3, 6 gives 4. Any other code ends the command with `error` and makes no memory request.
- R2: With `dir_x`=1 the leftmost column is the programmed x. With `dir_x`=0 the leftmost column is x+1-width. `dir_y` works the same way for y and height. Source and destination both follow this rule with the same width and height.
- R3: With `sel_operand`=1 the source uses `src_pitch`/`src_base` and the destination uses `dst_pitch`/`dst_base`. With `sel_operand`=0 both use `dflt_pitch`/`dflt_base`, and the unselected values have no effect.
- R4: If the pitch selected for either operand is zero, the command is rejected.
- R5: The command is rejected if an operand base is at or above the memory size, if base + start_x + (start_y + height) * pitch is at or above the memory size, or if a start coordinate would fall below zero.
- R6: After a copy, `pos_x` becomes start_x+width when `dir_x`=1 and start_x when `dir_x`=0. `pos_y` becomes start_y+height when `dir_y`=1 and start_y when `dir_y`=0. The values are destination start coordinates. Both positions hold their values at all other times, including after a rejected command.
- R7: Byte (column, row) of the source rectangle lands at the same (column, row) of the destination rectangle. Addresses are base + row*pitch + x*bytes_per_pixel + byte. Columns are walked in descending order when `dir_x`=0, and rows bottom-first when `dir_y`=0, so overlapping copies are exact.
- R8: `start` is taken only while `busy` is low, and operands are captured at that edge. Each byte takes one read cycle and one write cycle. `done` rises 2+2N cycles after the start edge, for N bytes. `error` rises 2 cycles after it. Each is a one-cycle pulse, and memory requests happen only while `busy` is high.
- R9: A width or height of zero is rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Command pulse, accepted while idle |
| fmt_code | input | 4 | Pixel format code |
| dir_x | input | 1 | 1: x is the left edge; 0: x is the right edge |
| dir_y | input | 1 | 1: y is the top edge; 0: y is the bottom edge |
| sel_operand | input | 1 | 1: per-operand pitch/base; 0: shared defaults |
| src_x | input | COORD_W | Source x coordinate |
| src_y | input | COORD_W | Source y coordinate |
| dst_x | input | COORD_W | Destination x coordinate |
| dst_y | input | COORD_W | Destination y coordinate |
| width | input | COORD_W | Width in pixels |
| height | input | COORD_W | Height in rows |
| src_pitch | input | PITCH_W | Source row pitch in bytes |
| dst_pitch | input | PITCH_W | Destination row pitch in bytes |
| dflt_pitch | input | PITCH_W | Shared default pitch |
| src_base | input | OFS_W | Source base byte address |
| dst_base | input | OFS_W | Destination base byte address |
| dflt_base | input | OFS_W | Shared default base |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | One-cycle rejection pulse |
| pos_x | output | COORD_W | Written-back destination x |
| pos_y | output | COORD_W | Written-back destination y |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | MEM_AW | Byte address |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data, valid the cycle after a read |

## Verification
The hardest case to reach from the ports is a copy whose source and destination overlap while the walk runs backwards. There, a wrong order only shows up as bytes overwritten before they are read. The stimulus fills memory with a pattern in which every nearby byte is distinct. It then runs overlapping shifts to the right, downwards and diagonally, each with the direction bits that make the programmed corner the far edge. After each run the whole memory is compared with a model that copies from a snapshot. A second hard case is a start pulse arriving mid-copy with different operands. The bench raises one while the engine is busy and checks that the memory image still matches the first command.

// File: rtl/rce_pkg.sv
// Package: shared state encoding and pixel-format decode for the rectangle copy engine.
// Assumes one memory word holds one byte; pixels occupy 1..4 consecutive words.
package rce_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CHECK = 2'd1,
        ST_RD    = 2'd2,
        ST_WR    = 2'd3
    } rce_state_t;

    // Bytes per pixel for a format code; zero marks an unsupported code.
    function automatic logic [2:0] fmt_bytes(input logic [3:0] code);
        case (code)
            4'd2:       return 3'd1;
            4'd3, 4'd4: return 3'd2;
            4'd5:       return 3'd3;
            4'd6:       return 3'd4;
            default:    return 3'd0;
        endcase
    endfunction

endpackage

// File: rtl/rce_origin.sv
// Module: converts a programmed coordinate pair into the top-left start corner.
// A clear direction bit means the programmed value is the far edge. The extra
// top bit of each result flags a start that would fall below zero. Assumes a
// non-zero extent; a zero extent is rejected elsewhere.
module rce_origin #(
    parameter int COORD_W = 12
) (
    input  logic [COORD_W-1:0] pos_x,
    input  logic [COORD_W-1:0] pos_y,
    input  logic [COORD_W-1:0] ext_w,
    input  logic [COORD_W-1:0] ext_h,
    input  logic               dir_x,
    input  logic               dir_y,
    output logic [COORD_W-1:0] start_x,
    output logic [COORD_W-1:0] start_y,
    output logic               under
);

    logic [COORD_W:0] ox;
    logic [COORD_W:0] oy;

    // Far-edge to near-edge conversion with a sign bit kept.
    always_comb begin
        ox = dir_x ? {1'b0, pos_x}
                   : {1'b0, pos_x} + (COORD_W+1)'(1) - {1'b0, ext_w};
        oy = dir_y ? {1'b0, pos_y}
                   : {1'b0, pos_y} + (COORD_W+1)'(1) - {1'b0, ext_h};
    end

    assign start_x = ox[COORD_W-1:0];
    assign start_y = oy[COORD_W-1:0];
    assign under   = ox[COORD_W] | oy[COORD_W];

endmodule

// File: rtl/rce_bounds.sv
// Module: range check and first-row address for one operand.
// Rejects a zero pitch, a base at/after the memory end, and an extent whose
// limit base + x + (y + h) * pitch reaches the memory end. The first address
// points at the leftmost byte of the row walked first (top or bottom).
module rce_bounds #(
    parameter int MEM_SIZE = 4096,
    parameter int COORD_W  = 12,
    parameter int PITCH_W  = 12,
    parameter int OFS_W    = 16,
    parameter int MEM_AW   = 12
) (
    input  logic [COORD_W-1:0] start_x,
    input  logic [COORD_W-1:0] start_y,
    input  logic [COORD_W-1:0] ext_h,
    input  logic               dir_y,
    input  logic [OFS_W-1:0]   base,
    input  logic [PITCH_W-1:0] pitch,
    input  logic [2:0]         bpb,
    output logic [MEM_AW-1:0]  first_addr,
    output logic               reject
);

    localparam int BW = OFS_W + COORD_W + PITCH_W + 4;

    logic [BW-1:0]      limit;
    logic [COORD_W-1:0] row0;

    // Conservative end-of-extent limit and validity decision.
    always_comb begin
        limit  = BW'(base) + BW'(start_x) + (BW'(start_y) + BW'(ext_h)) * BW'(pitch);
        reject = (pitch == '0) || (BW'(base) >= BW'(MEM_SIZE)) || (limit >= BW'(MEM_SIZE));
    end

    // Row walked first: top row for downward walks, bottom row otherwise.
    always_comb begin
        row0       = dir_y ? start_y : start_y + ext_h - COORD_W'(1);
        first_addr = MEM_AW'(base) + MEM_AW'(row0) * MEM_AW'(pitch)
                   + MEM_AW'(start_x) * MEM_AW'(bpb);
    end

endmodule

// File: rtl/rce_walker.sv
// Module: byte-granular scan over a rectangle for source and destination at once.
// Steps a column counter across a row of row_bytes bytes, then moves both row
// pointers by their pitch, up or down as dir_y says. dir_x picks ascending or
// descending byte order inside a row. Operands must stay stable from load on.
module rce_walker #(
    parameter int MEM_AW  = 12,
    parameter int COORD_W = 12,
    parameter int RB_W    = 15
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic               step,
    input  logic               dir_x,
    input  logic               dir_y,
    input  logic [RB_W-1:0]    row_bytes,
    input  logic [COORD_W-1:0] rows,
    input  logic [MEM_AW-1:0]  src_first,
    input  logic [MEM_AW-1:0]  dst_first,
    input  logic [MEM_AW-1:0]  src_pitch,
    input  logic [MEM_AW-1:0]  dst_pitch,
    output logic [MEM_AW-1:0]  src_addr,
    output logic [MEM_AW-1:0]  dst_addr,
    output logic               last
);

    logic [RB_W-1:0]    col;
    logic [COORD_W-1:0] row;
    logic [MEM_AW-1:0]  s_row;
    logic [MEM_AW-1:0]  d_row;
    logic [RB_W-1:0]    offset;
    logic               row_end;

    assign row_end = (col == row_bytes - RB_W'(1));
    assign last    = row_end && (row == rows - COORD_W'(1));

    // Byte offset in the row, mirrored for right-to-left walks.
    always_comb begin
        offset   = dir_x ? col : row_bytes - RB_W'(1) - col;
        src_addr = s_row + MEM_AW'(offset);
        dst_addr = d_row + MEM_AW'(offset);
    end

    // Column and row advance with pitch stepping at row ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col   <= '0;
            row   <= '0;
            s_row <= '0;
            d_row <= '0;
        end else if (load) begin
            col   <= '0;
            row   <= '0;
            s_row <= src_first;
            d_row <= dst_first;
        end else if (step) begin
            if (row_end) begin
                col   <= '0;
                row   <= row + COORD_W'(1);
                s_row <= dir_y ? s_row + src_pitch : s_row - src_pitch;
                d_row <= dir_y ? d_row + dst_pitch : d_row - dst_pitch;
            end else begin
                col <= col + RB_W'(1);
            end
        end
    end

endmodule

// File: rtl/rce_engine.sv
// Module: top of the rectangle copy engine.
// Captures a command on start while idle, checks it for one cycle, then copies
// byte by byte (read cycle, write cycle) through a memory port whose read data
// arrives one cycle after the request. It ends with a done or error pulse and
// writes back the destination position after a successful copy.
module rce_engine #(
    parameter int MEM_SIZE = 4096,
    parameter int COORD_W  = 12,
    parameter int PITCH_W  = 12,
    parameter int OFS_W    = 16,
    parameter int DATA_W   = 8,
    localparam int MEM_AW  = $clog2(MEM_SIZE)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [3:0]         fmt_code,
    input  logic               dir_x,
    input  logic               dir_y,
    input  logic               sel_operand,
    input  logic [COORD_W-1:0] src_x,
    input  logic [COORD_W-1:0] src_y,
    input  logic [COORD_W-1:0] dst_x,
    input  logic [COORD_W-1:0] dst_y,
    input  logic [COORD_W-1:0] width,
    input  logic [COORD_W-1:0] height,
    input  logic [PITCH_W-1:0] src_pitch,
    input  logic [PITCH_W-1:0] dst_pitch,
    input  logic [PITCH_W-1:0] dflt_pitch,
    input  logic [OFS_W-1:0]   src_base,
    input  logic [OFS_W-1:0]   dst_base,
    input  logic [OFS_W-1:0]   dflt_base,
    output logic               busy,
    output logic               done,
    output logic               error,
    output logic [COORD_W-1:0] pos_x,
    output logic [COORD_W-1:0] pos_y,
    output logic               mem_req,
    output logic               mem_we,
    output logic [MEM_AW-1:0]  mem_addr,
    output logic [DATA_W-1:0]  mem_wdata,
    input  logic [DATA_W-1:0]  mem_rdata
);

    import rce_pkg::*;

    localparam int RB_W   = COORD_W + 3;
    localparam int N_OPND = 2;   // index 0 = source, 1 = destination

    rce_state_t state;

    logic [3:0]         c_fmt;
    logic               c_dx, c_dy, c_sel;
    logic [COORD_W-1:0] c_sx, c_sy, c_tx, c_ty, c_w, c_h;
    logic [PITCH_W-1:0] c_sp, c_tp, c_fp;
    logic [OFS_W-1:0]   c_sb, c_tb, c_fb;

    logic [2:0]         bpb;
    logic [RB_W-1:0]    row_bytes;
    logic               cmd_bad;

    logic [COORD_W-1:0] op_x     [N_OPND];
    logic [COORD_W-1:0] op_y     [N_OPND];
    logic [COORD_W-1:0] op_sx    [N_OPND];
    logic [COORD_W-1:0] op_sy    [N_OPND];
    logic [PITCH_W-1:0] op_pitch [N_OPND];
    logic [OFS_W-1:0]   op_base  [N_OPND];
    logic [MEM_AW-1:0]  op_first [N_OPND];
    logic [N_OPND-1:0]  op_under;
    logic [N_OPND-1:0]  op_rej;

    logic [MEM_AW-1:0]  w_src, w_dst;
    logic               w_last;

    // Capture command operands when a start is taken in idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_fmt <= '0; c_dx <= 1'b0; c_dy <= 1'b0; c_sel <= 1'b0;
            c_sx  <= '0; c_sy <= '0;   c_tx <= '0;   c_ty  <= '0;
            c_w   <= '0; c_h  <= '0;
            c_sp  <= '0; c_tp <= '0;   c_fp <= '0;
            c_sb  <= '0; c_tb <= '0;   c_fb <= '0;
        end else if (state == ST_IDLE && start) begin
            c_fmt <= fmt_code; c_dx <= dir_x; c_dy <= dir_y; c_sel <= sel_operand;
            c_sx  <= src_x;    c_sy <= src_y; c_tx <= dst_x; c_ty  <= dst_y;
            c_w   <= width;    c_h  <= height;
            c_sp  <= src_pitch; c_tp <= dst_pitch; c_fp <= dflt_pitch;
            c_sb  <= src_base;  c_tb <= dst_base;  c_fb <= dflt_base;
        end
    end

    // Route captured values to the per-operand checkers, applying the set select.
    always_comb begin
        op_x[0]     = c_sx;
        op_y[0]     = c_sy;
        op_x[1]     = c_tx;
        op_y[1]     = c_ty;
        op_pitch[0] = c_sel ? c_sp : c_fp;
        op_pitch[1] = c_sel ? c_tp : c_fp;
        op_base[0]  = c_sel ? c_sb : c_fb;
        op_base[1]  = c_sel ? c_tb : c_fb;
    end

    generate
        for (genvar g = 0; g < N_OPND; g++) begin : g_opnd
            rce_origin #(
                .COORD_W (COORD_W)
            ) u_origin (
                .pos_x   (op_x[g]),
                .pos_y   (op_y[g]),
                .ext_w   (c_w),
                .ext_h   (c_h),
                .dir_x   (c_dx),
                .dir_y   (c_dy),
                .start_x (op_sx[g]),
                .start_y (op_sy[g]),
                .under   (op_under[g])
            );

            rce_bounds #(
                .MEM_SIZE (MEM_SIZE),
                .COORD_W  (COORD_W),
                .PITCH_W  (PITCH_W),
                .OFS_W    (OFS_W),
                .MEM_AW   (MEM_AW)
            ) u_bounds (
                .start_x    (op_sx[g]),
                .start_y    (op_sy[g]),
                .ext_h      (c_h),
                .dir_y      (c_dy),
                .base       (op_base[g]),
                .pitch      (op_pitch[g]),
                .bpb        (bpb),
                .first_addr (op_first[g]),
                .reject     (op_rej[g])
            );
        end
    endgenerate

    // Whole-command validity and row length in bytes.
    always_comb begin
        bpb       = fmt_bytes(c_fmt);
        row_bytes = RB_W'(c_w) * RB_W'(bpb);
        cmd_bad   = (bpb == 3'd0) || (c_w == '0) || (c_h == '0)
                  || (|op_under) || (|op_rej);
    end

    rce_walker #(
        .MEM_AW  (MEM_AW),
        .COORD_W (COORD_W),
        .RB_W    (RB_W)
    ) u_walker (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (state == ST_CHECK && !cmd_bad),
        .step      (state == ST_WR),
        .dir_x     (c_dx),
        .dir_y     (c_dy),
        .row_bytes (row_bytes),
        .rows      (c_h),
        .src_first (op_first[0]),
        .dst_first (op_first[1]),
        .src_pitch (MEM_AW'(op_pitch[0])),
        .dst_pitch (MEM_AW'(op_pitch[1])),
        .src_addr  (w_src),
        .dst_addr  (w_dst),
        .last      (w_last)
    );

    // Sequencer: check, then alternate read and write until the last byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            done  <= 1'b0;
            error <= 1'b0;
            pos_x <= '0;
            pos_y <= '0;
        end else begin
            done  <= 1'b0;
            error <= 1'b0;
            case (state)
                ST_IDLE:  if (start) state <= ST_CHECK;
                ST_CHECK: begin
                    if (cmd_bad) begin
                        error <= 1'b1;
                        state <= ST_IDLE;
                    end else begin
                        state <= ST_RD;
                    end
                end
                ST_RD:    state <= ST_WR;
                ST_WR: begin
                    if (w_last) begin
                        done  <= 1'b1;
                        state <= ST_IDLE;
                        pos_x <= c_dx ? op_sx[1] + c_w : op_sx[1];
                        pos_y <= c_dy ? op_sy[1] + c_h : op_sy[1];
                    end else begin
                        state <= ST_RD;
                    end
                end
                default:  state <= ST_IDLE;
            endcase
        end
    end

    // Memory port: read from the source pointer, write the returned byte back out.
    always_comb begin
        busy      = (state != ST_IDLE);
        mem_req   = (state == ST_RD) || (state == ST_WR);
        mem_we    = (state == ST_WR);
        mem_addr  = mem_we ? w_dst : w_src;
        mem_wdata = mem_rdata;
    end

endmodule

// File: rtl/rce_engine_chk.sv
// Module: temporal checks on the copy engine's handshake, port use and position
// write-back. Attached to every rce_engine instance by the bind below.
module rce_engine_chk #(
    parameter int COORD_W = 12
) (
    input logic               clk,
    input logic               rst_n,
    input logic               busy,
    input logic               done,
    input logic               error,
    input logic               mem_req,
    input logic               mem_we,
    input logic [COORD_W-1:0] pos_x,
    input logic [COORD_W-1:0] pos_y
);

    AST_REQ_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n) mem_req |-> busy); // R8
    AST_DONE_NOT_ERR:  assert property (@(posedge clk) disable iff (!rst_n) done |-> !error); // R8
    AST_DONE_PULSE:    assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R8
    AST_ERR_PULSE:     assert property (@(posedge clk) disable iff (!rst_n) error |=> !error); // R8
    AST_ERR_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n) error |-> !$past(mem_req)); // R1
    AST_POS_HOLD:      assert property (@(posedge clk) disable iff (!rst_n) !done |-> ($stable(pos_x) && $stable(pos_y))); // R6
    AST_WR_AFTER_RD:   assert property (@(posedge clk) disable iff (!rst_n) (mem_req && mem_we) |-> $past(mem_req && !mem_we)); // R7

endmodule

bind rce_engine rce_engine_chk #(.COORD_W(COORD_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy    (busy),
    .done    (done),
    .error   (error),
    .mem_req (mem_req),
    .mem_we  (mem_we),
    .pos_x   (pos_x),
    .pos_y   (pos_y)
);

// File: tb/rce_engine_tb.sv
`timescale 1ns/1ps
module rce_engine_tb;

    localparam int MEM = 4096;
    localparam int CW  = 12;
    localparam int PW  = 12;
    localparam int OW  = 16;
    localparam int AW  = 12;

    typedef struct packed {
        logic [3:0]  fmt;
        logic        xd, yd, so_sel;
        logic [11:0] sx, sy, dx, dy, w, h, sp, dp, fp;
        logic [15:0] sb, db, fb;
        logic        err;
    } vec_t;

    // fmt xd yd sel  sx sy dx dy  w h  sp dp fp  sb db fb  err
    localparam vec_t VECS [15] = '{
        '{4'd2, 1'b1, 1'b1, 1'b1, 12'd2,  12'd1, 12'd3,  12'd2,  12'd5, 12'd3, 12'd64, 12'd64, 12'd0,   16'd0,    16'd1024, 16'd0,    1'b0},
        '{4'd2, 1'b0, 1'b1, 1'b0, 12'd14, 12'd3, 12'd16, 12'd3,  12'd6, 12'd2, 12'd0,  12'd0,  12'd64,  16'd0,    16'd0,    16'd0,    1'b0},
        '{4'd6, 1'b1, 1'b0, 1'b0, 12'd1,  12'd5, 12'd1,  12'd7,  12'd3, 12'd4, 12'd0,  12'd0,  12'd64,  16'd0,    16'd0,    16'd256,  1'b0},
        '{4'd3, 1'b0, 1'b0, 1'b1, 12'd8,  12'd6, 12'd9,  12'd7,  12'd4, 12'd3, 12'd32, 12'd32, 12'd0,   16'd512,  16'd512,  16'd0,    1'b0},
        '{4'd5, 1'b1, 1'b1, 1'b0, 12'd0,  12'd0, 12'd20, 12'd1,  12'd4, 12'd2, 12'd0,  12'd0,  12'd100, 16'd5000, 16'd0,    16'd2048, 1'b0},
        '{4'd4, 1'b1, 1'b1, 1'b1, 12'd1,  12'd1, 12'd2,  12'd3,  12'd5, 12'd2, 12'd40, 12'd40, 12'd0,   16'd100,  16'd3000, 16'd9000, 1'b0},
        '{4'd7, 1'b1, 1'b1, 1'b1, 12'd0,  12'd0, 12'd0,  12'd0,  12'd2, 12'd2, 12'd64, 12'd64, 12'd64,  16'd0,    16'd1024, 16'd0,    1'b1},
        '{4'd0, 1'b1, 1'b1, 1'b1, 12'd0,  12'd0, 12'd0,  12'd0,  12'd2, 12'd2, 12'd64, 12'd64, 12'd64,  16'd0,    16'd1024, 16'd0,    1'b1},
        '{4'd2, 1'b1, 1'b1, 1'b1, 12'd0,  12'd0, 12'd0,  12'd0,  12'd2, 12'd2, 12'd0,  12'd64, 12'd64,  16'd0,    16'd1024, 16'd0,    1'b1},
        '{4'd2, 1'b1, 1'b1, 1'b0, 12'd0,  12'd0, 12'd0,  12'd0,  12'd2, 12'd2, 12'd64, 12'd64, 12'd0,   16'd0,    16'd1024, 16'd0,    1'b1},
        '{4'd2, 1'b1, 1'b1, 1'b1, 12'd0,  12'd0, 12'd0,  12'd0,  12'd2, 12'd2, 12'd64, 12'd64, 12'd64,  16'd0,    16'd4096, 16'd0,    1'b1},
        '{4'd2, 1'b1, 1'b1, 1'b1, 12'd0,  12'd0, 12'd2,  12'd60, 12'd3, 12'd4, 12'd64, 12'd64, 12'd64,  16'd0,    16'd0,    16'd0,    1'b1},
        '{4'd2, 1'b1, 1'b1, 1'b1, 12'd0,  12'd0, 12'd2,  12'd59, 12'd3, 12'd4, 12'd64, 12'd64, 12'd64,  16'd0,    16'd0,    16'd0,    1'b0},
        '{4'd2, 1'b0, 1'b1, 1'b1, 12'd10, 12'd0, 12'd2,  12'd0,  12'd5, 12'd2, 12'd64, 12'd64, 12'd64,  16'd0,    16'd1024, 16'd0,    1'b1},
        '{4'd2, 1'b1, 1'b1, 1'b1, 12'd0,  12'd0, 12'd0,  12'd0,  12'd0, 12'd2, 12'd64, 12'd64, 12'd64,  16'd0,    16'd1024, 16'd0,    1'b1}
    };
    // Requirement each vector mainly targets.
    localparam string VREQ [15] = '{"R7", "R7", "R7", "R7", "R3", "R3", "R1", "R1",
                                    "R4", "R4", "R5", "R5", "R5", "R2", "R9"};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [3:0]    fmt_code = '0;
    logic          dir_x = 1'b0, dir_y = 1'b0, sel_operand = 1'b0;
    logic [CW-1:0] src_x = '0, src_y = '0, dst_x = '0, dst_y = '0, width = '0, height = '0;
    logic [PW-1:0] src_pitch = '0, dst_pitch = '0, dflt_pitch = '0;
    logic [OW-1:0] src_base = '0, dst_base = '0, dflt_base = '0;
    logic          busy, done, error, mem_req, mem_we;
    logic [CW-1:0] pos_x, pos_y;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_wdata;
    logic [7:0]    mem_rdata = '0;

    logic [7:0]    vmem    [MEM];
    logic [7:0]    ref_mem [MEM];
    logic [7:0]    snap    [MEM];
    logic          fill = 1'b0;
    int            fill_seed = 0;
    int            checks = 0, failures = 0, cycles = 0;
    int            exp_px = 0, exp_py = 0;

    always #4 clk = ~clk;

    rce_engine #(
        .MEM_SIZE (MEM), .COORD_W (CW), .PITCH_W (PW), .OFS_W (OW), .DATA_W (8)
    ) u_dut (
        .clk (clk), .rst_n (rst_n), .start (start), .fmt_code (fmt_code),
        .dir_x (dir_x), .dir_y (dir_y), .sel_operand (sel_operand),
        .src_x (src_x), .src_y (src_y), .dst_x (dst_x), .dst_y (dst_y),
        .width (width), .height (height),
        .src_pitch (src_pitch), .dst_pitch (dst_pitch), .dflt_pitch (dflt_pitch),
        .src_base (src_base), .dst_base (dst_base), .dflt_base (dflt_base),
        .busy (busy), .done (done), .error (error), .pos_x (pos_x), .pos_y (pos_y),
        .mem_req (mem_req), .mem_we (mem_we), .mem_addr (mem_addr),
        .mem_wdata (mem_wdata), .mem_rdata (mem_rdata)
    );

    function automatic logic [7:0] pat(int i, int s);
        return 8'((i * 29) ^ (i >> 7) ^ (s * 53));
    endfunction

    // Behavioural memory: bulk fill, or one-cycle-latency read / write.
    always @(posedge clk) begin
        if (fill) begin
            for (int i = 0; i < MEM; i++) vmem[i] <= pat(i, fill_seed);
        end else if (mem_req) begin
            if (mem_we) vmem[mem_addr] <= mem_wdata;
            else        mem_rdata <= vmem[mem_addr];
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            failures = failures + 1;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int bytes_of(input logic [3:0] f);
        case (f)
            4'd2: return 1;
            4'd3, 4'd4: return 2;
            4'd5: return 3;
            4'd6: return 4;
            default: return 0;
        endcase
    endfunction

    function automatic int near_edge(input int p, input int e, input logic d);
        return d ? p : p + 1 - e;
    endfunction

    // Apply one command, optionally disturb it mid-copy, and check every outcome.
    task automatic run_vec(input vec_t v, input int seed, input string req, input bit disturb);
        int bpb, sb, db, sp, dp, ssx, ssy, dsx, dsy, k, nb, bad;
        @(negedge clk);
        fmt_code = v.fmt; dir_x = v.xd; dir_y = v.yd; sel_operand = v.so_sel;
        src_x = v.sx; src_y = v.sy; dst_x = v.dx; dst_y = v.dy; width = v.w; height = v.h;
        src_pitch = v.sp; dst_pitch = v.dp; dflt_pitch = v.fp;
        src_base = v.sb; dst_base = v.db; dflt_base = v.fb;
        fill_seed = seed; fill = 1'b1;
        @(negedge clk);
        fill = 1'b0;
        for (int i = 0; i < MEM; i++) begin ref_mem[i] = pat(i, seed); snap[i] = ref_mem[i]; end
        bpb = bytes_of(v.fmt);
        nb  = int'(v.w) * int'(v.h) * bpb;
        if (!v.err) begin
            sb = v.so_sel ? int'(v.sb) : int'(v.fb);
            db = v.so_sel ? int'(v.db) : int'(v.fb);
            sp = v.so_sel ? int'(v.sp) : int'(v.fp);
            dp = v.so_sel ? int'(v.dp) : int'(v.fp);
            ssx = near_edge(v.sx, v.w, v.xd); ssy = near_edge(v.sy, v.h, v.yd);
            dsx = near_edge(v.dx, v.w, v.xd); dsy = near_edge(v.dy, v.h, v.yd);
            for (int r = 0; r < int'(v.h); r++)
                for (int c = 0; c < int'(v.w) * bpb; c++)
                    ref_mem[(db + (dsy + r) * dp + dsx * bpb + c) % MEM] =
                        snap[(sb + (ssy + r) * sp + ssx * bpb + c) % MEM];
            exp_px = v.xd ? (dsx + int'(v.w)) % MEM : dsx;
            exp_py = v.yd ? (dsy + int'(v.h)) % MEM : dsy;
        end
        start = 1'b1;
        k = 0;
        while (k < 40000) begin
            @(posedge clk);
            @(negedge clk);
            start = 1'b0;
            k++;
            if (disturb && k == 3) begin
                check(busy == 1'b1, "R8", "busy during copy", busy, 1);
                start = 1'b1; dst_base = 16'd0; dst_x = 12'd1; width = 12'd1;
            end
            if (done || error) break;
        end
        start = 1'b0;
        check(v.err ? (error && !done) : (done && !error), req,
              "completion kind (1=error)", int'(error), int'(v.err));
        check(k == (v.err ? 2 : 2 + 2 * nb), "R8", "cycles to completion", k, v.err ? 2 : 2 + 2 * nb);
        bad = 0;
        for (int i = 0; i < MEM; i++) if (vmem[i] !== ref_mem[i]) bad++;
        check(bad == 0, req, "memory bytes differing from model", bad, 0);
        check(int'(pos_x) == exp_px && int'(pos_y) == exp_py, "R6", "written-back x*4096+y",
              int'(pos_x) * MEM + int'(pos_y), exp_px * MEM + exp_py);
        @(negedge clk);
        check(!done && !error && !busy, "R8", "pulses gone a cycle later", {done, error, busy}, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // Reset state
        check(!busy && !done && !error && !mem_req, "R8", "idle outputs after reset",
              {busy, done, error, mem_req}, 0);
        check(pos_x == '0 && pos_y == '0, "R6", "positions after reset", int'(pos_x) + int'(pos_y), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !mem_req, "R8", "no activity without start", {busy, mem_req}, 0);
        // Table walk
        for (int n = 0; n < 15; n++) run_vec(VECS[n], n + 1, VREQ[n], 1'b0);
        // Directed: a second start and changed operands while busy have no effect
        run_vec(VECS[0], 77, "R8", 1'b1);
        // Directed: multi-byte overlapping right shift walked right to left (R7, R2)
        run_vec('{4'd6, 1'b0, 1'b0, 1'b0, 12'd6, 12'd4, 12'd7, 12'd4, 12'd5, 12'd3,
                  12'd0, 12'd0, 12'd48, 16'd0, 16'd0, 16'd1500, 1'b0}, 91, "R7", 1'b0);
        // Directed: source start underflow in y rejects (R5)
        run_vec('{4'd2, 1'b1, 1'b0, 1'b1, 12'd0, 12'd1, 12'd0, 12'd9, 12'd2, 12'd4,
                  12'd64, 12'd64, 12'd64, 16'd0, 16'd1024, 16'd0, 1'b1}, 5, "R5", 1'b0);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule